// File: doc/BRIEF.md
# Link Power-Up Reset Sequencer

This block brings a serial link controller and its PHY out of reset in a fixed order. When `start` is asserted, it parks the PHY in test power-down with the reference clock off and link training disabled. It then holds the active-low endpoint reset line low for a long reset window and releases it. At that point it powers the PHY up, enables the reference clock and, when the option is built in, raises a power-enable line. After a clock-settle window it enables link training.

Once training is enabled, the sequencer samples the `link_up` input at the end of each poll interval. It stops polling after a bounded number of samples. The outcome is reported on the `done` and `fail` flags. A new `start` pulse restarts the whole sequence from the beginning, whatever state the sequencer is in.

Every delay is given in microseconds and turned into clock cycles from a clock-frequency parameter. This lets a scaled-down configuration run quickly in test. The block also drives a set of fixed PHY tuning values on configuration outputs.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst` is high, and afterwards until the first `start`, outputs are `phy_test_pd`=1, `refclk_en`=0, `train_en`=0, `ep_rst_n`=0, `pwr_en`=0, `done`=0 and `fail`=0.
- R2: In the cycles after a clock edge that samples `start`=1, `phy_test_pd`=1, `refclk_en`=0, `train_en`=0 and `ep_rst_n`=0. This state lasts exactly RST_CYC cycles.
- R3: After the reset window, in the same cycle, `ep_rst_n` rises, `phy_test_pd` falls and `refclk_en` rises. `ep_rst_n` is never high while `refclk_en` is low.
- R4: `pwr_en` rises together with `ep_rst_n` when `HAS_PWR_EN`=1. It stays 0 in every cycle when `HAS_PWR_EN`=0.
- R5: `train_en` rises exactly SETTLE_CYC cycles after `ep_rst_n` rises. `train_en` is never high unless `refclk_en`=1, `ep_rst_n`=1 and `phy_test_pd`=0.
- R6: `link_up` is sampled only at the clock edge that ends each POLL_CYC-cycle interval after training starts. A high `link_up` before training starts, or inside an interval, has no effect.
- R7: If `link_up` is 1 at the end of poll interval k (0-based, k < MAX_POLLS), then from that edge on `done`=1 and `fail`=0 while `train_en` stays 1.
- R8: If `link_up` is 0 at the ends of all MAX_POLLS intervals, then from the last of those edges on `done`=1 and `fail`=1. `fail` is never 1 without `done`.
- R9: `start` restarts the sequence from any state, including mid-reset, mid-poll and after completion. In the next cycle `ep_rst_n`=0, `train_en`=0 and `done`=0.
- R10: The configuration outputs are fixed at the following values: port type 4 (root port), loss-of-signal level 9, full swing 127, low swing 127, Gen2 6 dB de-emphasis 20, Gen1 de-emphasis 0 and Gen2 3.5 dB de-emphasis 0.
- R11: Each window length in cycles is CLK_KHZ*US/1000, with a minimum of 1. RST_CYC comes from RESET_US, SETTLE_CYC from SETTLE_US and POLL_CYC from POLL_US.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the bring-up sequence |
| link_up | input | 1 | Link-up indication from the controller |
| phy_test_pd | output | 1 | PHY test power-down |
| refclk_en | output | 1 | Reference clock enable |
| train_en | output | 1 | Link-training enable |
| ep_rst_n | output | 1 | Active-low endpoint reset |
| pwr_en | output | 1 | Optional endpoint power enable |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Link never came up (valid with done) |
| cfg_port_type | output | 4 | Port type code |
| cfg_los_lvl | output | 6 | Loss-of-signal level |
| cfg_deemph_g1 | output | 6 | Gen1 de-emphasis |
| cfg_deemph_g2_3p5 | output | 6 | Gen2 3.5 dB de-emphasis |
| cfg_deemph_g2_6 | output | 6 | Gen2 6 dB de-emphasis |
| cfg_swing_full | output | 7 | Full TX swing |
| cfg_swing_low | output | 7 | Low TX swing |

## Verification
On every cycle, the assertions check the output ordering rules. Training only runs with the clock on, the PHY powered and the endpoint out of reset. `fail` only appears with `done`, and `start` always drops the reset line in the next cycle. A successful completion must follow a sampled `link_up` during training. The exact lengths of the reset, settle and poll windows can only be shown by the bench's scenarios. The same goes for which poll sample sees the link, for `link_up` being ignored outside the sample edges, and for restarts from mid-sequence. The bench compares every output in every cycle against a timeline it computes from the window lengths.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_POLL   = 3'd3,
        ST_UP     = 3'd4,
        ST_FAIL   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic test_pd;
        logic refclk_en;
        logic train_en;
        logic ep_rst_n;
        logic pwr_en;
        logic done;
        logic fail;
    } ctrl_out_t;

    typedef struct packed {
        logic [3:0] port_type;
        logic [5:0] los_lvl;
        logic [5:0] deemph_g1;
        logic [5:0] deemph_g2_3p5;
        logic [5:0] deemph_g2_6;
        logic [6:0] swing_full;
        logic [6:0] swing_low;
    } phy_cfg_t;

    localparam phy_cfg_t PHY_CFG_DEFAULT = '{
        port_type:     4'd4,
        los_lvl:       6'd9,
        deemph_g1:     6'd0,
        deemph_g2_3p5: 6'd0,
        deemph_g2_6:   6'd20,
        swing_full:    7'd127,
        swing_low:     7'd127
    };

    // Window length in cycles from a clock rate in kHz and a time in us.
    function automatic int us_to_cycles(input int khz, input int us);
        longint prod;
        prod = (longint'(khz) * longint'(us)) / 64'sd1000;
        if (prod < 64'sd1) return 1;
        return int'(prod);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_timed(input seq_state_e s);
        return (s == ST_RESET) || (s == ST_SETTLE) || (s == ST_POLL);
    endfunction

endpackage

// File: rtl/link_bringup_timer.sv
module link_bringup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] last_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = (cnt == last_val);

    always_ff @(posedge clk) begin
        if (rst || clr || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/link_bringup_attempts.sv
module link_bringup_attempts #(
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int AW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(MAX_POLLS - 1);

    logic [AW-1:0] n;

    assign last = (n == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n <= '0;
        end else if (inc && !last) begin
            n <= n + 1'b1;
        end
    end
endmodule

// File: rtl/link_bringup_decode.sv
module link_bringup_decode
    import link_bringup_pkg::*;
#(
    parameter bit HAS_PWR_EN = 1'b1
) (
    input  seq_state_e state,
    output ctrl_out_t  ctl
);
    ctrl_out_t base;

    always_comb begin
        base = '{test_pd: 1'b1, refclk_en: 1'b0, train_en: 1'b0,
                 ep_rst_n: 1'b0, pwr_en: 1'b0, done: 1'b0, fail: 1'b0};
        case (state)
            ST_SETTLE: begin
                base.test_pd   = 1'b0;
                base.refclk_en = 1'b1;
                base.ep_rst_n  = 1'b1;
                base.pwr_en    = 1'b1;
            end
            ST_POLL, ST_UP, ST_FAIL: begin
                base.test_pd   = 1'b0;
                base.refclk_en = 1'b1;
                base.ep_rst_n  = 1'b1;
                base.pwr_en    = 1'b1;
                base.train_en  = 1'b1;
                base.done      = (state != ST_POLL);
                base.fail      = (state == ST_FAIL);
            end
            default: ;
        endcase
    end

    generate
        if (HAS_PWR_EN) begin : g_pwr
            assign ctl = base;
        end else begin : g_nopwr
            always_comb begin
                ctl        = base;
                ctl.pwr_en = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import link_bringup_pkg::*;
#(
    parameter int CLK_KHZ    = 125000,
    parameter int RESET_US   = 100000,
    parameter int SETTLE_US  = 150,
    parameter int POLL_US    = 500,
    parameter int MAX_POLLS  = 10,
    parameter bit HAS_PWR_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       link_up,
    output logic       phy_test_pd,
    output logic       refclk_en,
    output logic       train_en,
    output logic       ep_rst_n,
    output logic       pwr_en,
    output logic       done,
    output logic       fail,
    output logic [3:0] cfg_port_type,
    output logic [5:0] cfg_los_lvl,
    output logic [5:0] cfg_deemph_g1,
    output logic [5:0] cfg_deemph_g2_3p5,
    output logic [5:0] cfg_deemph_g2_6,
    output logic [6:0] cfg_swing_full,
    output logic [6:0] cfg_swing_low
);
    localparam int RST_CYC    = us_to_cycles(CLK_KHZ, RESET_US);
    localparam int SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
    localparam int POLL_CYC   = us_to_cycles(CLK_KHZ, POLL_US);
    localparam int MAX_CYC    = max3(RST_CYC, SETTLE_CYC, POLL_CYC);
    localparam int TW         = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] RST_LAST    = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] POLL_LAST   = TW'(POLL_CYC - 1);

    seq_state_e    state, state_nxt;
    logic [TW-1:0] win_last;
    logic          tmr_clr, tmr_exp;
    logic          att_inc, att_last;
    ctrl_out_t     ctl;

    always_comb begin
        case (state)
            ST_RESET:  win_last = RST_LAST;
            ST_SETTLE: win_last = SETTLE_LAST;
            default:   win_last = POLL_LAST;
        endcase
    end

    assign tmr_clr = start || !is_timed(state);
    assign att_inc = (state == ST_POLL) && tmr_exp && !link_up;

    link_bringup_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .last_val (win_last),
        .expired  (tmr_exp)
    );

    link_bringup_attempts #(.MAX_POLLS(MAX_POLLS)) u_attempts (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .inc  (att_inc),
        .last (att_last)
    );

    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = ST_RESET;
        end else begin
            case (state)
                ST_RESET:  if (tmr_exp) state_nxt = ST_SETTLE;
                ST_SETTLE: if (tmr_exp) state_nxt = ST_POLL;
                ST_POLL: begin
                    if (tmr_exp) begin
                        if (link_up)       state_nxt = ST_UP;
                        else if (att_last) state_nxt = ST_FAIL;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    link_bringup_decode #(.HAS_PWR_EN(HAS_PWR_EN)) u_decode (
        .state (state),
        .ctl   (ctl)
    );

    assign phy_test_pd = ctl.test_pd;
    assign refclk_en   = ctl.refclk_en;
    assign train_en    = ctl.train_en;
    assign ep_rst_n    = ctl.ep_rst_n;
    assign pwr_en      = ctl.pwr_en;
    assign done        = ctl.done;
    assign fail        = ctl.fail;

    assign cfg_port_type     = PHY_CFG_DEFAULT.port_type;
    assign cfg_los_lvl       = PHY_CFG_DEFAULT.los_lvl;
    assign cfg_deemph_g1     = PHY_CFG_DEFAULT.deemph_g1;
    assign cfg_deemph_g2_3p5 = PHY_CFG_DEFAULT.deemph_g2_3p5;
    assign cfg_deemph_g2_6   = PHY_CFG_DEFAULT.deemph_g2_6;
    assign cfg_swing_full    = PHY_CFG_DEFAULT.swing_full;
    assign cfg_swing_low     = PHY_CFG_DEFAULT.swing_low;
endmodule

// File: rtl/link_bringup_chk.sv
module link_bringup_chk #(
    parameter bit HAS_PWR_EN = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic link_up,
    input logic phy_test_pd,
    input logic refclk_en,
    input logic train_en,
    input logic ep_rst_n,
    input logic pwr_en,
    input logic done,
    input logic fail
);
    // R5: training only with clock on, PHY powered, endpoint released
    assert_train_gated_R5: assert property (@(posedge clk) disable iff (rst)
        train_en |-> (refclk_en && ep_rst_n && !phy_test_pd));

    // R3: endpoint released only with clock running and PHY powered
    assert_rstn_with_clk_R3: assert property (@(posedge clk) disable iff (rst)
        ep_rst_n |-> (refclk_en && !phy_test_pd));

    // R8: fail only together with done
    assert_fail_has_done_R8: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R9: start always drops the endpoint reset and training next cycle
    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ep_rst_n && !train_en && !done && phy_test_pd));

    // R7: completion without start keeps its result
    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail)));

    // R6: success follows a sampled link_up while training
    assert_up_after_link_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !fail) |-> ($past(link_up) && $past(train_en)));

    // R4: power enable absent when the option is off
    generate
        if (!HAS_PWR_EN) begin : g_nopwr
            assert_pwr_off_R4: assert property (@(posedge clk) disable iff (rst)
                !pwr_en);
        end else begin : g_pwr
            assert_pwr_with_rstn_R4: assert property (@(posedge clk) disable iff (rst)
                pwr_en == ep_rst_n);
        end
    endgenerate
endmodule

bind link_bringup_seq link_bringup_chk #(.HAS_PWR_EN(HAS_PWR_EN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .link_up     (link_up),
    .phy_test_pd (phy_test_pd),
    .refclk_en   (refclk_en),
    .train_en    (train_en),
    .ep_rst_n    (ep_rst_n),
    .pwr_en      (pwr_en),
    .done        (done),
    .fail        (fail)
);

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;
    localparam int KHZ = 1000;
    localparam int RUS = 40;
    localparam int SUS = 15;
    localparam int PUS = 6;
    localparam int MP  = 4;
    // R11: window lengths computed in the bench
    localparam int R = KHZ * RUS / 1000;
    localparam int S = KHZ * SUS / 1000;
    localparam int P = KHZ * PUS / 1000;

    logic clk = 1'b0;
    logic rst, start, link_up;
    logic pd, ck, tr, rn, pw, dn, fl;
    logic npd, nck, ntr, nrn, npw, ndn, nfl;
    logic [3:0] c_pt;
    logic [5:0] c_los, c_g1, c_g35, c_g6;
    logic [6:0] c_sf, c_sl;
    logic [3:0] n_pt;
    logic [5:0] n_los, n_g1, n_g35, n_g6;
    logic [6:0] n_sf, n_sl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    link_bringup_seq #(.CLK_KHZ(KHZ), .RESET_US(RUS), .SETTLE_US(SUS),
        .POLL_US(PUS), .MAX_POLLS(MP), .HAS_PWR_EN(1'b1)) u_link_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .link_up(link_up),
        .phy_test_pd(pd), .refclk_en(ck), .train_en(tr), .ep_rst_n(rn),
        .pwr_en(pw), .done(dn), .fail(fl),
        .cfg_port_type(c_pt), .cfg_los_lvl(c_los), .cfg_deemph_g1(c_g1),
        .cfg_deemph_g2_3p5(c_g35), .cfg_deemph_g2_6(c_g6),
        .cfg_swing_full(c_sf), .cfg_swing_low(c_sl));

    link_bringup_seq #(.CLK_KHZ(KHZ), .RESET_US(RUS), .SETTLE_US(SUS),
        .POLL_US(PUS), .MAX_POLLS(MP), .HAS_PWR_EN(1'b0)) u_link_bringup_seq_nopwr (
        .clk(clk), .rst(rst), .start(start), .link_up(link_up),
        .phy_test_pd(npd), .refclk_en(nck), .train_en(ntr), .ep_rst_n(nrn),
        .pwr_en(npw), .done(ndn), .fail(nfl),
        .cfg_port_type(n_pt), .cfg_los_lvl(n_los), .cfg_deemph_g1(n_g1),
        .cfg_deemph_g2_3p5(n_g35), .cfg_deemph_g2_6(n_g6),
        .cfg_swing_full(n_sf), .cfg_swing_low(n_sl));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected {pd, clk, train, rst_n, pwr, done, fail} at cycle j after start
    function automatic logic [6:0] expv(input int j, input int k, input bit pwr);
        int fin;
        fin = (k < MP) ? (R + S + P * (k + 1)) : (R + S + P * MP);
        if (j < R)      return 7'b1000000;
        if (j < R + S)  return {4'b0101, pwr, 2'b00};
        if (j < fin)    return {4'b0111, pwr, 2'b00};
        return {4'b0111, pwr, 1'b1, (k >= MP)};
    endfunction

    function automatic string tag_of(input int j, input int k);
        int fin;
        fin = (k < MP) ? (R + S + P * (k + 1)) : (R + S + P * MP);
        if (j == 0)      return "R2/R9";
        if (j < R)       return "R2";
        if (j == R)      return "R3";
        if (j < R + S)   return "R3";
        if (j == R + S)  return "R5";
        if (j < fin)     return "R6";
        return (k < MP) ? "R7" : "R8";
    endfunction

    task automatic check_cycle(input int j, input int k);
        logic [6:0] e1, e2;
        e1 = expv(j, k, 1'b1);
        e2 = expv(j, k, 1'b0);
        chk({pd, ck, tr, rn, pw, dn, fl} == e1, tag_of(j, k), "outputs",
            int'({pd, ck, tr, rn, pw, dn, fl}), int'(e1));
        chk({npd, nck, ntr, nrn, npw, ndn, nfl} == e2, "R4", "nopwr outputs",
            int'({npd, nck, ntr, nrn, npw, ndn, nfl}), int'(e2));
    endtask

    // k < MP: link seen at poll sample k; k == MP: never seen
    task automatic run(input int k);
        int fin;
        fin = (k < MP) ? (R + S + P * (k + 1)) : (R + S + P * MP);
        link_up = (k == 0);   // k==0: high from the start, ignored until sampled (R6)
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        for (int j = 0; j <= fin + 3; j++) begin
            check_cycle(j, k);
            if (k > 0 && k < MP && j == fin - P) link_up = 1'b1;
            @(posedge clk); #2;
        end
        link_up = 1'b0;
    endtask

    task automatic partial(input int cycles);
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (cycles) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; link_up = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk({pd, ck, tr, rn, pw, dn, fl} == 7'b1000000, "R1", "in reset",
            int'({pd, ck, tr, rn, pw, dn, fl}), 'h40);
        rst = 1'b0;
        link_up = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        chk({pd, ck, tr, rn, pw, dn, fl} == 7'b1000000, "R1", "idle ignores link_up",
            int'({pd, ck, tr, rn, pw, dn, fl}), 'h40);
        link_up = 1'b0;
        // R10: fixed configuration values
        chk(c_pt == 4'd4,    "R10", "port type", c_pt, 4);
        chk(c_los == 6'd9,   "R10", "los level", c_los, 9);
        chk(c_sf == 7'd127,  "R10", "swing full", c_sf, 127);
        chk(c_sl == 7'd127,  "R10", "swing low", c_sl, 127);
        chk(c_g6 == 6'd20,   "R10", "g2 6dB", c_g6, 20);
        chk(c_g1 == 6'd0,    "R10", "g1", c_g1, 0);
        chk(c_g35 == 6'd0,   "R10", "g2 3.5dB", c_g35, 0);
        chk(n_pt == 4'd4 && n_g6 == 6'd20, "R10", "nopwr cfg", n_g6, 20);
        // R11: each poll sample position, then never
        for (int k = 0; k <= MP; k++) run(k);
        // R9: restart mid-poll, mid-reset, mid-settle
        partial(R + S + P + 2);
        run(2);
        partial(R / 2);
        run(MP);
        partial(R + 3);
        run(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule